// File: doc/BRIEF.md
# Chained Serial Setup Loader

This block loads the setup word of one device that sits in a chain of identical devices sharing one serial data line and one serial clock. While its active-low enable input is held low, each rising edge of the serial clock shifts one data bit into a setup shift register. A bit counter tracks how many bits have been taken. When the last bit of the configured length arrives, the device counts as loaded and its setup word is frozen.

From that point on, the device stops taking bits. Its active-low enable output copies the enable input, and its serial output copies the serial input, both without a register in the path. The next device in the chain, wired to these two outputs, then takes the bits that follow. The enable output of the last device goes low only once every device is loaded, and that low level marks the device ready for normal work. Until a device is loaded, its enable output stays high and its serial output stays low.

An active-low master reset, asserted asynchronously and released on the serial clock, clears the register, the counter and the loaded state. The device must then be programmed again from the first bit.

Top module: `serial_cfg_loader`

## Requirements
- R1: While master reset is asserted, the enable output is high, the serial output is low and the setup word is all zeros.
- R2: On a rising serial-clock edge with the enable input high, the setup word and the bit count do not change.
- R3: Each captured bit enters bit 0 of the setup word and every earlier bit moves up one position, so that after CFG_BITS captured bits the first bit sent sits at bit CFG_BITS-1.
- R4: Until CFG_BITS bits have been captured, the enable output is high and the serial output is low, whatever the serial and enable inputs are.
- R5: From the edge that captures bit number CFG_BITS, the enable output equals the enable input (low when it is low, high when it is high) in the same cycle.
- R6: Once loaded, the serial output equals the serial input in the same cycle.
- R7: Once loaded, further rising edges leave the setup word unchanged, whatever the enable input is.
- R8: A master reset during loading discards the bits taken so far: afterwards the device needs a full CFG_BITS captured bits to become loaded.
- R9: With two devices chained (serial output to serial input, enable output to enable input), the second device captures only the bits sent after the first one is loaded, and its enable output goes low only when both are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert, released on sclk |
| sdi | input | 1 | Serial data input |
| sen_in_n | input | 1 | Serial enable input, active low |
| sdo | output | 1 | Serial data output; low before loading, copy of sdi after |
| sen_out_n | output | 1 | Serial enable output; high before loading, copy of sen_in_n after |
| cfg | output | CFG_BITS | Setup word held in the shift register |

## Verification
The bench builds two chained instances, the first with CFG_BITS set to 8 and the second with 5, so that full loads of both, the hand-over between them and the last-bit boundary of each counter are reached in a few dozen cycles. The unequal lengths make an off-by-one in the counter show up as a misplaced hand-over point in the second device. A master reset in the middle of loading the first device, followed by exactly one bit short of a full load, reaches the case where a stale partial count would end loading early.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Width of a counter that must hold values 0 .. n-1, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CFG_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic loaded
);

  localparam int unsigned CW = cnt_width(CFG_BITS);
  localparam logic [CW-1:0] LAST = CW'(CFG_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (step) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign loaded = done_q;

  // R5: loaded state is sticky until master reset
  p_loaded_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R4: loading ends only on a step taken at the last count
  p_load_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(cnt_q) == LAST) && $past(step));

  // R8: the count never leaves its range
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int unsigned CFG_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [CFG_BITS-1:0] word
);

  logic [CFG_BITS-1:0] word_q, word_d;

  generate
    if (CFG_BITS == 1) begin : g_single
      always_comb word_d = bit_in;
    end else begin : g_multi
      always_comb word_d = {word_q[CFG_BITS-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (shift_en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

  // R2: without a shift request the word holds
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));

  // R3: a shifted bit lands in position 0
  p_new_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word_q[0] == $past(bit_in));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int unsigned CFG_BITS = 64
) (
  input  logic                sclk,
  input  logic                mrst_n,
  input  logic                sdi,
  input  logic                sen_in_n,
  output logic                sdo,
  output logic                sen_out_n,
  output logic [CFG_BITS-1:0] cfg
);

  logic rst_n;
  logic loaded;
  logic take_bit;

  cfg_rst_sync u_rst (
    .clk    (sclk),
    .arst_n (mrst_n),
    .srst_n (rst_n)
  );

  assign take_bit = !sen_in_n && !loaded;

  cfg_bit_counter #(.CFG_BITS(CFG_BITS)) u_cnt (
    .clk    (sclk),
    .rst_n  (rst_n),
    .step   (take_bit),
    .loaded (loaded)
  );

  cfg_shift_reg #(.CFG_BITS(CFG_BITS)) u_sr (
    .clk      (sclk),
    .rst_n    (rst_n),
    .shift_en (take_bit),
    .bit_in   (sdi),
    .word     (cfg)
  );

  // Pass-through once loaded; quiet levels before.
  assign sen_out_n = loaded ? sen_in_n : 1'b1;
  assign sdo       = loaded ? sdi      : 1'b0;

  // R7: the setup word is frozen once the counter reports loaded
  p_frozen_after_load_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    loaded |=> $stable(cfg));

  // R1: reset holds the word clear
  p_reset_clear_r1: assert property (@(posedge sclk)
    !rst_n |-> cfg == '0);

endmodule

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;

  localparam int NA = 8;
  localparam int NB = 5;

  logic          sclk = 1'b0;
  logic          mrst_n;
  logic          sdi;
  logic          sen_in_n;
  logic          so_a, seno_a, so_b, seno_b;
  logic [NA-1:0] cfg_a;
  logic [NB-1:0] cfg_b;

  always #4 sclk = ~sclk;

  serial_cfg_loader #(.CFG_BITS(NA)) dut (
    .sclk(sclk), .mrst_n(mrst_n), .sdi(sdi), .sen_in_n(sen_in_n),
    .sdo(so_a), .sen_out_n(seno_a), .cfg(cfg_a)
  );

  serial_cfg_loader #(.CFG_BITS(NB)) dut_b (
    .sclk(sclk), .mrst_n(mrst_n), .sdi(so_a), .sen_in_n(seno_a),
    .sdo(so_b), .sen_out_n(seno_b), .cfg(cfg_b)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench reference model
  logic [NA-1:0] ea_cfg;
  logic [NB-1:0] eb_cfg;
  int            ea_cnt, eb_cnt;
  bit            ea_ld, eb_ld;

  function automatic logic exp_seno(input bit ld, input logic en_n);
    return ld ? en_n : 1'b1;
  endfunction

  function automatic logic exp_so(input bit ld, input logic d);
    return ld ? d : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    ea_cfg = '0; eb_cfg = '0; ea_cnt = 0; eb_cnt = 0; ea_ld = 0; eb_ld = 0;
  endtask

  task automatic compare_all();
    chk(ea_ld ? "R7" : "R3", 64'(cfg_a), 64'(ea_cfg));
    chk(ea_ld ? "R5" : "R4", 64'(seno_a), 64'(exp_seno(ea_ld, sen_in_n)));
    chk(ea_ld ? "R6" : "R4", 64'(so_a), 64'(exp_so(ea_ld, sdi)));
    chk("R9", 64'(cfg_b), 64'(eb_cfg));
    chk("R9", 64'(seno_b), 64'(exp_seno(eb_ld, exp_seno(ea_ld, sen_in_n))));
    chk("R9", 64'(so_b), 64'(exp_so(eb_ld, exp_so(ea_ld, sdi))));
  endtask

  task automatic step(input logic b, input logic en_n);
    logic pa_so, pa_seno;
    @(negedge sclk);
    sdi = b;
    sen_in_n = en_n;
    #1;
    compare_all();
    pa_so   = exp_so(ea_ld, b);
    pa_seno = exp_seno(ea_ld, en_n);
    @(posedge sclk);
    #1;
    if (!pa_seno && !eb_ld) begin
      eb_cfg = {eb_cfg[NB-2:0], pa_so};
      eb_cnt++;
      if (eb_cnt == NB) eb_ld = 1;
    end
    if (!en_n && !ea_ld) begin
      ea_cfg = {ea_cfg[NA-2:0], b};
      ea_cnt++;
      if (ea_cnt == NA) ea_ld = 1;
    end
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge sclk);
    mrst_n = 1'b0;
    sen_in_n = 1'b1;
    sdi = 1'($urandom);
    #1;
    model_reset();
    chk("R1", 64'(cfg_a), 64'd0);
    chk("R1", 64'(seno_a), 64'd1);
    chk("R1", 64'(so_a), 64'd0);
    chk("R1", 64'(cfg_b), 64'd0);
    repeat (2) @(negedge sclk);
    mrst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'($urandom), 1'b1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mrst_n = 1'b0;
    sdi = 1'b0;
    sen_in_n = 1'b1;
    model_reset();
    #1;
    chk("R1", 64'(cfg_a), 64'd0);
    chk("R1", 64'(seno_a), 64'd1);
    chk("R1", 64'(so_a), 64'd0);
    do_reset();

    // R2: disabled edges with random data shift nothing
    for (int i = 0; i < 6; i++) step(1'($urandom), 1'b1);
    chk("R2", 64'(cfg_a), 64'd0);

    // Directed start: 1 then 0 so the top bits are known (R3)
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // Random bits with random idle cycles until device A is one short
    while (ea_cnt < NA - 1) step(1'($urandom), 1'($urandom_range(0, 3) == 0));
    chk("R4", 64'(seno_a), 64'd1);
    step(1'($urandom), 1'b0);
    chk("R5", 64'(seno_a), 64'd0);
    chk("R3", 64'(cfg_a[NA-1:NA-2]), 64'd2);

    // R5 follow high and low, R6 pass-through
    step(1'b1, 1'b1);
    chk("R5", 64'(seno_a), 64'd1);
    chk("R6", 64'(so_a), 64'd1);
    step(1'b0, 1'b1);
    chk("R6", 64'(so_a), 64'd0);

    // Load device B through A, random pattern
    while (!eb_ld) step(1'($urandom), 1'($urandom_range(0, 3) == 0));
    chk("R9", 64'(seno_b), 64'd0);

    // R7: extra traffic leaves both words frozen
    for (int i = 0; i < 20; i++) step(1'($urandom), 1'($urandom));
    chk("R7", 64'(cfg_a), 64'(ea_cfg));

    // R8: reset in the middle of loading
    do_reset();
    for (int i = 0; i < 3; i++) step(1'($urandom), 1'b0);
    do_reset();
    for (int i = 0; i < NA - 1; i++) step(1'($urandom), 1'b0);
    chk("R8", 64'(seno_a), 64'd1);
    step(1'b1, 1'b0);
    chk("R8", 64'(seno_a), 64'd0);
    chk("R8", 64'(cfg_a), 64'(ea_cfg));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule